// File: doc/BRIEF.md
# 24-bit Three-Wire Serial Register Master

This block gives on-chip logic access to the registers of an external device over a three-wire serial link, with an optional fourth line for read data. A client presents one register request at a time on a valid/ready command port. Each request carries an 8-bit register number, a 16-bit write value and a direction flag. The block turns every request into two 24-bit frames. The first frame selects the register. The second frame either carries the value or fetches the register contents.

Frames go out most-significant bit first, framed by an active-low select. The serial clock idles high and each bit takes two half-periods of programmable length. When the request is finished, a single-cycle completion strobe is raised. For reads, the result is valid in the same cycle as the strobe. A build parameter removes the read-data line; reads then return zero.

Top module: `spi24_reg_master`

## Requirements
- R1: After reset and whenever no request is in progress, spi_csn_o, spi_sck_o and spi_sdo_o are all 1, req_ready_o is 1 and done_o is 0.
- R2: Every frame has exactly 24 rising edges of spi_sck_o while spi_csn_o is 0, and the bits are sent most-significant first.
- R3: A write of value V to register N produces two frames: first 0x70_00_NN, then 0x72_VVVV.
- R4: A read of register N produces two frames: first 0x70_00_NN, then 0x73_0000. rdata_o equals the low 16 bits sampled on spi_sdi_i during the second frame, each sampled just before a rising clock edge.
- R5: spi_sck_o stays low for exactly HALF_CYC cycles for each bit, and stays high for exactly HALF_CYC cycles between consecutive bits. spi_sdo_o changes only when spi_sck_o falls.
- R6: Each frame starts with spi_csn_o falling 2*HALF_CYC cycles before the first clock fall. spi_csn_o rises 3*HALF_CYC cycles after the last clock rise, which is one high half plus one guard interval. Between frames, spi_csn_o stays high for at least 2*HALF_CYC cycles.
- R7: req_ready_o is 0 from the cycle after a request is accepted until the completion strobe. A request presented while req_ready_o is 0 has no effect on the frames sent or on the result returned.
- R8: done_o is high for exactly one cycle per request, and req_ready_o is 1 in that cycle. After a write, rdata_o is 0 in that cycle.
- R9: With HAS_SDI = 0, rdata_o is 0 after every read, whatever level spi_sdi_i has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_reg_i | input | 8 | Register number |
| req_wdata_i | input | 16 | Value to write |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 16 | Read result, valid while done_o is 1 |
| spi_csn_o | output | 1 | Serial select, active low |
| spi_sck_o | output | 1 | Serial clock, idles high |
| spi_sdo_o | output | 1 | Serial data to the device |
| spi_sdi_i | input | 1 | Serial data from the device |

## Verification
The hardest property to check is that the read result comes only from the last 16 bits of the second frame. Bits from the register-select frame, and the top byte of the second frame, must never leak into the result. To exercise this, the bench models the device. It answers every frame with a distinct pattern and places noise in the upper byte of the read frame. A wrong capture window therefore always produces a wrong value. A second case is a request held on the port while the block is busy. The bench keeps a conflicting request asserted during a transfer and then checks that the frames it decoded match only the original request.

// File: rtl/spi24_pkg.sv
package spi24_pkg;
  localparam int FRAME_W = 24;
  localparam int REG_W   = 8;
  localparam int VAL_W   = 16;

  localparam logic [7:0] PFX_ADDR = 8'h70;
  localparam logic [7:0] PFX_WR   = 8'h72;
  localparam logic [7:0] PFX_RD   = 8'h73;

  typedef enum logic [2:0] {F_IDLE, F_LEAD, F_LOW, F_HIGH, F_TRAIL, F_GAP} frame_st_e;
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} seq_st_e;

  function automatic logic [FRAME_W-1:0] addr_frame(logic [REG_W-1:0] r);
    return {PFX_ADDR, {(FRAME_W-8-REG_W){1'b0}}, r};
  endfunction

  function automatic logic [FRAME_W-1:0] data_frame(logic wr, logic [VAL_W-1:0] v);
    return wr ? {PFX_WR, v} : {PFX_RD, {VAL_W{1'b0}}};
  endfunction
endpackage

// File: rtl/spi24_tick.sv
module spi24_tick #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi24_frame.sv
module spi24_frame
  import spi24_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int RX_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] data_i,
  output logic               done_o,
  output logic [RX_W-1:0]    rx_o,
  output logic               csn_o,
  output logic               sck_o,
  output logic               sdo_o,
  input  logic               sdi_i
);
  localparam int BIT_W = $clog2(FRAME_W);

  frame_st_e          st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BIT_W-1:0]   bits_q;
  logic               half_q;
  logic               tick;

  spi24_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != F_IDLE),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      sh_q   <= '0;
      bits_q <= '0;
      half_q <= 1'b0;
      rx_o   <= '0;
      csn_o  <= 1'b1;
      sck_o  <= 1'b1;
      sdo_o  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        F_IDLE: if (start_i) begin
          sh_q   <= data_i;
          half_q <= 1'b0;
          csn_o  <= 1'b0;
          st_q   <= F_LEAD;
        end
        F_LEAD: if (tick) begin
          if (half_q) begin
            sck_o  <= 1'b0;
            sdo_o  <= sh_q[FRAME_W-1];
            sh_q   <= sh_q << 1;
            bits_q <= BIT_W'(FRAME_W - 1);
            st_q   <= F_LOW;
          end else half_q <= 1'b1;
        end
        F_LOW: if (tick) begin
          // sample right before the rising edge
          rx_o  <= {rx_o[RX_W-2:0], sdi_i};
          sck_o <= 1'b1;
          st_q  <= F_HIGH;
        end
        F_HIGH: if (tick) begin
          if (bits_q == '0) begin
            half_q <= 1'b0;
            st_q   <= F_TRAIL;
          end else begin
            bits_q <= bits_q - 1'b1;
            sck_o  <= 1'b0;
            sdo_o  <= sh_q[FRAME_W-1];
            sh_q   <= sh_q << 1;
            st_q   <= F_LOW;
          end
        end
        F_TRAIL: if (tick) begin
          if (half_q) begin
            csn_o  <= 1'b1;
            half_q <= 1'b0;
            st_q   <= F_GAP;
          end else half_q <= 1'b1;
        end
        F_GAP: if (tick) begin
          if (half_q) begin
            sdo_o  <= 1'b1;
            done_o <= 1'b1;
            st_q   <= F_IDLE;
          end else half_q <= 1'b1;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi24_seq.sv
module spi24_seq
  import spi24_pkg::*;
#(
  parameter bit HAS_SDI = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [REG_W-1:0]   req_reg_i,
  input  logic [VAL_W-1:0]   req_wdata_i,
  input  logic               frame_done_i,
  input  logic [VAL_W-1:0]   rx_i,
  output logic               start_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_o,
  output logic [VAL_W-1:0]   rdata_o
);
  seq_st_e            st_q;
  logic [FRAME_W-1:0] nxt_q;
  logic               wr_q;
  logic [VAL_W-1:0]   rd_src;

  generate
    if (HAS_SDI) begin : g_sdi
      assign rd_src = rx_i;
    end else begin : g_nosdi
      assign rd_src = '0;
    end
  endgenerate

  assign req_ready_o = (st_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      nxt_q   <= '0;
      wr_q    <= 1'b0;
      start_o <= 1'b0;
      frame_o <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          frame_o <= addr_frame(req_reg_i);
          nxt_q   <= data_frame(req_write_i, req_wdata_i);
          start_o <= 1'b1;
          st_q    <= S_ADDR;
        end
        S_ADDR: if (frame_done_i) begin
          frame_o <= nxt_q;
          start_o <= 1'b1;
          st_q    <= S_DATA;
        end
        S_DATA: if (frame_done_i) begin
          rdata_o <= wr_q ? '0 : rd_src;
          done_o  <= 1'b1;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi24_reg_master.sv
module spi24_reg_master
  import spi24_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter bit HAS_SDI  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [REG_W-1:0] req_reg_i,
  input  logic [VAL_W-1:0] req_wdata_i,
  output logic             done_o,
  output logic [VAL_W-1:0] rdata_o,
  output logic             spi_csn_o,
  output logic             spi_sck_o,
  output logic             spi_sdo_o,
  input  logic             spi_sdi_i
);
  logic               f_start;
  logic [FRAME_W-1:0] f_data;
  logic               f_done;
  logic [VAL_W-1:0]   f_rx;

  spi24_seq #(.HAS_SDI(HAS_SDI)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_write_i  (req_write_i),
    .req_reg_i    (req_reg_i),
    .req_wdata_i  (req_wdata_i),
    .frame_done_i (f_done),
    .rx_i         (f_rx),
    .start_o      (f_start),
    .frame_o      (f_data),
    .done_o       (done_o),
    .rdata_o      (rdata_o)
  );

  spi24_frame #(.HALF_CYC(HALF_CYC), .RX_W(VAL_W)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (f_start),
    .data_i  (f_data),
    .done_o  (f_done),
    .rx_o    (f_rx),
    .csn_o   (spi_csn_o),
    .sck_o   (spi_sck_o),
    .sdo_o   (spi_sdo_o),
    .sdi_i   (spi_sdi_i)
  );
endmodule

// File: rtl/spi24_reg_master_chk.sv
module spi24_reg_master_chk #(
  parameter bit HAS_SDI = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic [15:0] rdata_o,
  input logic        spi_csn_o,
  input logic        spi_sck_o,
  input logic        spi_sdo_o
);
  // R1: idle lines high whenever a request can be taken
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (spi_csn_o && spi_sck_o && spi_sdo_o));

  // R5: data does not move on the rising clock edge
  a_r5_sdo_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_sck_o) |-> $stable(spi_sdo_o));

  // R6: clock never toggles outside a selected frame
  a_r6_sck_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_csn_o |-> spi_sck_o);

  // R7: accept drops ready in the next cycle
  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R8: one-cycle strobe following a busy period
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o && $past(!req_ready_o)));

  // R9: no read line, no read data
  a_r9_nosdi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !HAS_SDI) |-> (rdata_o == 16'h0));
endmodule

bind spi24_reg_master spi24_reg_master_chk #(.HAS_SDI(HAS_SDI)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .spi_csn_o   (spi_csn_o),
  .spi_sck_o   (spi_sck_o),
  .spi_sdo_o   (spi_sdo_o)
);

// File: tb/spi24_reg_master_bench.sv
`timescale 1ns/1ps
module spi24_reg_master_bench;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [7:0]  regn = '0;
  logic [15:0] wdata = '0;
  logic        ready, done, csn, sck, sdo;
  logic [15:0] rdata;
  logic        sdi = 1'b1;

  logic        n_valid = 1'b0;
  logic        n_ready, n_done, n_csn, n_sck, n_sdo;
  logic [15:0] n_rdata;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi24_reg_master #(.HALF_CYC(HALF), .HAS_SDI(1'b1)) u_spi24_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_write_i(write), .req_reg_i(regn), .req_wdata_i(wdata),
    .done_o(done), .rdata_o(rdata), .spi_csn_o(csn), .spi_sck_o(sck),
    .spi_sdo_o(sdo), .spi_sdi_i(sdi));

  spi24_reg_master #(.HALF_CYC(HALF), .HAS_SDI(1'b0)) u_spi24_reg_master_nosdi (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(n_valid), .req_ready_o(n_ready),
    .req_write_i(1'b0), .req_reg_i(8'h33), .req_wdata_i(16'h0),
    .done_o(n_done), .rdata_o(n_rdata), .spi_csn_o(n_csn), .spi_sck_o(n_sck),
    .spi_sdo_o(n_sdo), .spi_sdi_i(1'b1));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dev_val(input logic [7:0] r);
    return {r ^ 8'h5A, r};
  endfunction

  // device model and timing monitor
  logic [23:0] frames [0:63];
  int          fbits  [0:63];
  int nf = 0, cyc = 0, nb = 0;
  int fst = 0, low_c = 0, rise_c = 0, hi_c = 0;
  int lead_err = 0, trail_err = 0, gap_err = 0, half_err = 0;
  bit first = 0, have_hi = 0, p_csn = 1, p_sck = 1;
  logic [23:0] shr = '0, resp = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_csn = 1; p_sck = 1;
    end else begin
      if (p_csn && !csn) begin
        fst = cyc; nb = 0; shr = '0; first = 1;
        if (have_hi && (cyc - hi_c < 2*HALF)) gap_err++;
        if (nf > 0 && frames[nf-1][23:16] == 8'h70)
          resp = {8'hA5, dev_val(frames[nf-1][7:0])};
        else
          resp = 24'h3C3C3C;
      end
      if (!csn && p_sck && !sck) begin
        if (first) begin
          if (cyc - fst != 2*HALF) lead_err++;
          first = 0;
        end else if (cyc - rise_c != HALF) half_err++;
        low_c = cyc;
        if (nb < 24) sdi = resp[23-nb];
      end
      if (!csn && !p_sck && sck) begin
        if (cyc - low_c != HALF) half_err++;
        shr = {shr[22:0], sdo};
        nb++;
        rise_c = cyc;
      end
      if (!p_csn && csn) begin
        if (cyc - rise_c != 3*HALF) trail_err++;
        if (nf < 64) begin frames[nf] = shr; fbits[nf] = nb; nf++; end
        hi_c = cyc; have_hi = 1; sdi = 1'b1;
      end
      p_csn = csn; p_sck = sck;
    end
  end

  task automatic do_req(input bit w, input logic [7:0] r, input logic [15:0] v,
                        input bit noise, output logic [15:0] rd);
    int cnt;
    bit busy_bad;
    while (!ready) @(negedge clk);
    valid = 1; write = w; regn = r; wdata = v;
    @(negedge clk);
    chk(ready == 1'b0, "R7 ready low after accept", ready, 0);
    if (noise) begin write = ~w; regn = ~r; wdata = ~v; end
    else valid = 0;
    cnt = 0; busy_bad = 0;
    while (!done && cnt < 5000) begin
      if (ready) busy_bad = 1;
      if (cnt == 60) valid = 0;
      @(negedge clk);
      cnt++;
    end
    valid = 0;
    chk(!busy_bad, "R7 ready stays low while busy", busy_bad, 0);
    chk(done && ready, "R8 done with ready", {done, ready}, 2'b11);
    rd = rdata;
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  task automatic check_frames(input int base, input logic [23:0] f0, input logic [23:0] f1, input string tag);
    chk(nf == base + 2, {tag, " frame count"}, nf, base + 2);
    chk(fbits[base] == 24 && fbits[base+1] == 24, "R2 24 bits per frame",
        {fbits[base][15:0], fbits[base+1][15:0]}, {16'd24, 16'd24});
    chk(frames[base] == f0, {tag, " select frame"}, frames[base], f0);
    chk(frames[base+1] == f1, {tag, " second frame"}, frames[base+1], f1);
  endtask

  task automatic t_reset;
    chk(csn && sck && sdo, "R1 idle lines high", {csn, sck, sdo}, 3'b111);
    chk(ready && !done, "R1 ready high done low", {ready, done}, 2'b10);
  endtask

  task automatic t_write(input logic [7:0] r, input logic [15:0] v);
    logic [15:0] rd;
    int base = nf;
    do_req(1, r, v, 0, rd);
    check_frames(base, {8'h70, 8'h00, r}, {8'h72, v}, "R3");
    chk(rd == 16'h0, "R8 write returns zero", rd, 0);
    chk(csn && sck && sdo, "R1 idle after write", {csn, sck, sdo}, 3'b111);
  endtask

  task automatic t_read(input logic [7:0] r);
    logic [15:0] rd;
    int base = nf;
    do_req(0, r, 16'hBEEF, 0, rd);
    check_frames(base, {8'h70, 8'h00, r}, 24'h730000, "R4");
    chk(rd == dev_val(r), "R4 read data", rd, dev_val(r));
  endtask

  task automatic t_busy_noise;
    logic [15:0] rd;
    int base = nf;
    do_req(0, 8'h5C, 16'h1234, 1, rd);
    check_frames(base, {8'h70, 8'h00, 8'h5C}, 24'h730000, "R7 held request ignored");
    chk(rd == dev_val(8'h5C), "R7 result unaffected", rd, dev_val(8'h5C));
    repeat (4 * HALF) @(negedge clk);
    chk(nf == base + 2 && ready, "R7 no extra frames", nf, base + 2);
  endtask

  task automatic t_nosdi;
    int cnt = 0;
    while (!n_ready) @(negedge clk);
    n_valid = 1;
    @(negedge clk);
    n_valid = 0;
    while (!n_done && cnt < 5000) begin @(negedge clk); cnt++; end
    chk(n_done == 1'b1, "R9 completion seen", n_done, 1);
    chk(n_rdata == 16'h0, "R9 read data zero", n_rdata, 0);
  endtask

  task automatic t_timing;
    chk(half_err == 0, "R5 half-period lengths", half_err, 0);
    chk(lead_err == 0, "R6 select lead guard", lead_err, 0);
    chk(trail_err == 0, "R6 select trail guard", trail_err, 0);
    chk(gap_err == 0, "R6 select high gap", gap_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write(8'hB7, 16'h0343);
    t_write(8'h00, 16'hFFFF);
    t_write(8'hFF, 16'h0000);
    t_read(8'hB0);
    t_read(8'hFF);
    t_read(8'h00);
    t_busy_noise();
    t_nosdi();
    t_timing();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule